// File: doc/BRIEF.md
# Restoring Shift-Subtract Remainder Unit

This block takes an unsigned dividend and a non-zero unsigned divisor. It returns the remainder of the division and no quotient. A user pulses `start` with both operands on the inputs. The unit then works for a number of cycles that depends on the divisor. It raises `done` for exactly one cycle, and `remainder` carries the result from that cycle on.

The divisor is first shifted left until its top bit is set. A small up/down counter records how many places it moved. The unit then repeatedly subtracts the scaled divisor from a working register that is one bit wider than the data. That extra top bit serves as the sign of each trial difference. Whenever a trial difference goes negative, the divisor is added back. Between trials the divisor is shifted one place right and the counter steps down. When the counter reaches zero, the working register holds the remainder and the divisor register is back at its input value.

A zero divisor lies outside the intended range, but it cannot lock the unit up. Normalisation stops when the shift counter is full, and the dividend is returned unchanged.

Top module: `restoring_rem`

## Requirements
- R1: After reset `done` is 0 and `remainder` is 0.
- R2: For a non-zero divisor, `remainder` equals dividend modulo divisor when `done` is high.
- R3: A divisor whose bit 7 is already set needs no normalising shift and still gives the correct remainder.
- R4: A divisor of 1, which needs the full seven normalising shifts, gives a remainder of 0 for any dividend.
- R5: A divisor of 0 completes, and `remainder` then equals the dividend.
- R6: `done` is high for exactly one clock cycle per accepted operation.
- R7: `remainder` keeps its value after `done` until the next accepted `start`.
- R8: A `start` pulse while an operation is in progress is ignored, and the running operation's result is unaffected.
- R9: `done` rises no more than 4*DW clock edges after the edge that accepts `start`.
- R10: At completion the internal divisor register again holds the input divisor, the working register's sign bit is clear, and a non-zero divisor gives a remainder below the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| dividend | input | DW | Unsigned dividend, captured with `start` |
| divisor | input | DW | Unsigned divisor, captured with `start` |
| done | output | 1 | One-cycle pulse when the result is valid |
| remainder | output | DW | Remainder; holds until the next accepted start |

## Verification
Several divisors are aimed at the ends of the normalising loop. A divisor of 1 takes the longest path and exposes a counter that is off by one, which would leave a non-zero remainder or take too long. A divisor of 128 or more takes no shift at all and catches a unit that always shifts at least once. A zero divisor catches a unit that never leaves normalisation or that alters the dividend. A `start` pulse in mid-operation catches a controller that reloads its operands while busy. Checks after `done` catch a pulse longer than one cycle and an output that drifts before the next start.

// File: rtl/rem_pkg.sv
// Shared types for the remainder unit: controller states and ALU operations.
package rem_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NORM,
        ST_SUB,
        ST_FIX,
        ST_SHR,
        ST_FIN
    } rem_state_t;

    typedef enum logic {
        OP_SUB,
        OP_ADD
    } alu_op_t;
endpackage

// File: rtl/rem_alu.sv
// Combinational adder/subtractor for the working register.
// Assumes: the working value is DW+1 bits wide and the divisor is DW bits, unsigned.
module rem_alu
    import rem_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW:0]   w,
    input  logic [DW-1:0] d,
    input  alu_op_t       op,
    output logic [DW:0]   res
);
    logic [DW:0] d_ext;

    // zero-extend the divisor to the working width
    assign d_ext = {1'b0, d};

    // select the trial subtract or the restoring add
    always_comb begin
        if (op == OP_ADD) res = w + d_ext;
        else              res = w - d_ext;
    end
endmodule

// File: rtl/rem_counter.sv
// Up/down shift counter that counts normalising shifts and then walks them back.
// Assumes: synchronous active-low reset, and the count changes only while en or clr is high.
module rem_counter #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          down,
    output logic [CW-1:0] cnt,
    output logic          at_zero,
    output logic          at_max
);
    // hold, clear, or step the count
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (en)    cnt <= down ? cnt - 1'b1 : cnt + 1'b1;
    end

    // flags used by the controller
    assign at_zero = (cnt == '0);
    assign at_max  = (cnt == {CW{1'b1}});
endmodule

// File: rtl/rem_ctrl.sv
// Controller: sequences load, normalise, subtract/restore, shift-back and finish.
// Assumes: the status inputs come from registers, and start is ignored outside idle.
module rem_ctrl
    import rem_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    d_msb,
    input  logic    w_sign,
    input  logic    c_zero,
    input  logic    c_max,
    output logic    load,
    output logic    d_shl,
    output logic    d_shr,
    output logic    w_en,
    output alu_op_t alu_op,
    output logic    c_clr,
    output logic    c_en,
    output logic    c_down,
    output logic    done,
    output logic    busy
);
    rem_state_t state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state and control word
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        d_shl    = 1'b0;
        d_shr    = 1'b0;
        w_en     = 1'b0;
        alu_op   = OP_SUB;
        c_clr    = 1'b0;
        c_en     = 1'b0;
        c_down   = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    load     = 1'b1;
                    c_clr    = 1'b1;
                    state_nx = ST_NORM;
                end
            end
            ST_NORM: begin
                if (d_msb)      state_nx = ST_SUB;
                else if (c_max) state_nx = ST_FIN;
                else begin
                    d_shl = 1'b1;
                    c_en  = 1'b1;
                end
            end
            ST_SUB: begin
                w_en     = 1'b1;
                alu_op   = OP_SUB;
                state_nx = ST_FIX;
            end
            ST_FIX: begin
                if (w_sign) begin
                    w_en   = 1'b1;
                    alu_op = OP_ADD;
                end
                state_nx = c_zero ? ST_FIN : ST_SHR;
            end
            ST_SHR: begin
                d_shr    = 1'b1;
                c_en     = 1'b1;
                c_down   = 1'b1;
                state_nx = ST_SUB;
            end
            ST_FIN: begin
                done     = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/restoring_rem.sv
// Top: restoring remainder unit with a normalising divisor shift and no quotient.
// Assumes: unsigned operands; a zero divisor ends once the shift counter is full
// and leaves the dividend as the result.
module restoring_rem #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [DW-1:0] remainder
);
    import rem_pkg::*;

    localparam int CW = $clog2(DW);

    logic [DW:0]   w_q;
    logic [DW:0]   alu_res;
    logic [DW-1:0] d_q;
    logic          load, d_shl, d_shr, w_en;
    logic          c_clr, c_en, c_down, c_zero, c_max;
    logic          busy;
    alu_op_t       alu_op;
    logic [CW-1:0] cnt;

    rem_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .d_msb  (d_q[DW-1]),
        .w_sign (w_q[DW]),
        .c_zero (c_zero),
        .c_max  (c_max),
        .load   (load),
        .d_shl  (d_shl),
        .d_shr  (d_shr),
        .w_en   (w_en),
        .alu_op (alu_op),
        .c_clr  (c_clr),
        .c_en   (c_en),
        .c_down (c_down),
        .done   (done),
        .busy   (busy)
    );

    rem_alu #(.DW(DW)) u_alu (
        .w   (w_q),
        .d   (d_q),
        .op  (alu_op),
        .res (alu_res)
    );

    rem_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (c_clr),
        .en      (c_en),
        .down    (c_down),
        .cnt     (cnt),
        .at_zero (c_zero),
        .at_max  (c_max)
    );

    // working register: load the dividend or take the ALU result
    always_ff @(posedge clk) begin
        if (!rst_n)    w_q <= '0;
        else if (load) w_q <= {1'b0, dividend};
        else if (w_en) w_q <= alu_res;
    end

    // divisor register: load, shift left to normalise, shift right to restore
    always_ff @(posedge clk) begin
        if (!rst_n)     d_q <= '0;
        else if (load)  d_q <= divisor;
        else if (d_shl) d_q <= {d_q[DW-2:0], 1'b0};
        else if (d_shr) d_q <= {1'b0, d_q[DW-1:1]};
    end

    assign remainder = w_q[DW-1:0];
endmodule

// File: rtl/restoring_rem_chk.sv
// Checker for restoring_rem: keeps its own copy of the accepted operands and
// checks the result, the restored divisor and the output timing.
module restoring_rem_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [DW-1:0] dividend,
    input logic [DW-1:0] divisor,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] remainder,
    input logic [DW-1:0] d_q,
    input logic [DW:0]   w_q
);
    logic [DW-1:0] a_cap, b_cap;

    // capture the operands of each accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_cap <= '0;
            b_cap <= '0;
        end else if (start && !busy) begin
            a_cap <= dividend;
            b_cap <= divisor;
        end
    end

    a_r2_rem_value: assert property (@(posedge clk) disable iff (!rst_n)
        (done && b_cap != '0) |-> remainder == a_cap % b_cap);

    a_r5_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
        (done && b_cap == '0) |-> remainder == a_cap);

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_rem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(remainder));

    a_r10_div_restored: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (d_q == b_cap && !w_q[DW]));

    a_r10_rem_below: assert property (@(posedge clk) disable iff (!rst_n)
        (done && b_cap != '0) |-> remainder < b_cap);
endmodule

bind restoring_rem restoring_rem_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .remainder (remainder),
    .d_q       (d_q),
    .w_q       (w_q)
);

// File: tb/restoring_rem_test.sv
// Directed bench for restoring_rem: one task per scenario, each checking its own results.
module restoring_rem_test;
    localparam int DW = 8;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] dividend = '0;
    logic [DW-1:0] divisor = '0;
    logic          done;
    logic [DW-1:0] remainder;

    int total = 0;
    int bad = 0;

    restoring_rem #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .done(done), .remainder(remainder)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_rem(input int a, input int b);
        return (b == 0) ? a : a % b;
    endfunction

    // run one operation; returns edges from accept to done
    task automatic run_op(input int a, input int b, input string req, output int lat);
        @(negedge clk);
        dividend = a[DW-1:0];
        divisor  = b[DW-1:0];
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check(req, int'(remainder), ref_rem(a, b));
        if (b != 0) check("R10 below divisor", int'(remainder < b[DW-1:0]), 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 done", int'(done), 0);
        check("R1 remainder", int'(remainder), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_basic();
        int lat;
        run_op(100, 7, "R2 100/7", lat);
        run_op(9, 200, "R2 dividend below divisor", lat);
        run_op(0, 13, "R2 zero dividend", lat);
        run_op(77, 77, "R2 equal operands", lat);
    endtask

    task automatic t_msb_divisor();
        int lat;
        run_op(255, 128, "R3 divisor 128", lat);
        run_op(200, 255, "R3 divisor 255", lat);
        run_op(255, 255, "R3 255/255", lat);
    endtask

    task automatic t_div_one();
        int lat;
        run_op(255, 1, "R4 255/1", lat);
        check("R9 latency worst case", int'(lat <= 4*DW), 1);
        run_op(1, 1, "R4 1/1", lat);
    endtask

    task automatic t_zero_div();
        int lat;
        run_op(173, 0, "R5 zero divisor", lat);
        check("R5 completes", int'(lat < 200), 1);
    endtask

    task automatic t_pulse_hold();
        int lat;
        logic [DW-1:0] held;
        run_op(250, 6, "R2 250/6", lat);
        held = remainder;
        @(negedge clk);
        check("R6 done one cycle", int'(done), 0);
        repeat (5) @(negedge clk);
        check("R7 remainder held", int'(remainder), int'(held));
    endtask

    task automatic t_busy_start();
        int lat;
        @(negedge clk);
        dividend = 8'd200;
        divisor  = 8'd3;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        dividend = 8'd7;
        divisor  = 8'd5;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check("R8 start ignored while busy", int'(remainder), 200 % 3);
        run_op(7, 5, "R8 next op after ignored start", lat);
    endtask

    task automatic t_sweep();
        int lat;
        int worst = 0;
        for (int b = 0; b < 256; b++) begin
            run_op(255 - (b % 5), b, "R2 divisor sweep", lat);
            if (lat > worst) worst = lat;
        end
        check("R9 latency bound over sweep", int'(worst <= 4*DW), 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_msb_divisor();
        t_div_one();
        t_zero_div();
        t_pulse_hold();
        t_busy_start();
        t_sweep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule